// File: doc/BRIEF.md
# Decode-Stage Load-Use Stall and Branch Flush Controller

This block sits beside the decode stage of a five-stage in-order pipeline. It decides, every cycle, whether the front end runs freely or stalls, and whether the instruction just fetched must be discarded. A stall is needed when the instruction in EX is a load whose destination register is read by the instruction now in decode. The loaded value is not ready in time to be forwarded, so the block freezes the PC and the fetch/decode register for one cycle. In the same cycle it tells the ID/EX register to load all-zero control fields, which sends a bubble down the pipe.

When a branch resolved in decode is taken, the block raises a flush that zeroes the instruction held in the fetch/decode register, turning it into a nop. Branches are predicted not taken, so no flush happens otherwise. If a stall and a taken branch coincide, the stall wins and the branch is judged again on the next cycle, once its operands are ready. The branch comparator and target adder sit outside this block.

The block is combinational from its pipeline inputs to its four controls. The clock and reset are used only by the embedded assertions.

Top module: `hzd_ctrl`

## Requirements
- R1: When the EX load flag is 1 and the EX destination equals either decode source number (and is not the zero register), `idex_ctrl_zero` is 1 in the same cycle.
- R2: Whenever `idex_ctrl_zero` is 1, both `pc_we` and `ifid_we` are 0.
- R3: A load whose destination is the zero register (all ones, 31 for 5-bit numbers) never causes a stall, even when the sources equal it.
- R4: With the EX load flag at 0, no stall occurs whatever the register numbers are. Once EX holds the bubble, the stall therefore lasts exactly one cycle.
- R5: With no stall and the taken flag at 1, `if_flush` is 1 while `pc_we` and `ifid_we` stay 1.
- R6: With the taken flag at 0, `if_flush` is 0.
- R7: With no hazard and no taken branch, the outputs are `pc_we`=1, `ifid_we`=1, `idex_ctrl_zero`=0 and `if_flush`=0.
- R8: When a stall and a taken branch occur in the same cycle, the stall outputs apply and `if_flush` is 0.
- R9: A load destination that matches both sources at once gives the same single stall as a match on either source alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded assertions |
| rst_n | input | 1 | Active-low reset; disables the assertions |
| ex_mem_rd_en | input | 1 | Instruction in EX reads data memory (load) |
| ex_dst | input | REG_W | Destination register number of the EX instruction |
| dec_src_a | input | REG_W | First source register number in IF/ID |
| dec_src_b | input | REG_W | Second source register number in IF/ID |
| br_taken_id | input | 1 | Branch resolved in decode is taken |
| pc_we | output | 1 | PC may update |
| ifid_we | output | 1 | IF/ID register may update |
| idex_ctrl_zero | output | 1 | Load zeros into the ID/EX EX/MEM/WB control fields |
| if_flush | output | 1 | Zero the instruction field of IF/ID |

## Verification
The comparison is tried with a load matching only source A, only source B, both at once, and neither. These cases show whether each comparator is wired and ORed correctly. Non-load producers with matching numbers and loads to the zero register are applied to show that the memory-read qualifier and the zero-register exclusion are present. A sequence of a stall cycle followed by a bubble in EX shows that the stall ends after one cycle. Taken and not-taken branches are applied alone and together with a hazard, which separates the flush path from the stall path and shows which one has priority.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // Front-end action chosen for the current cycle.
  typedef enum logic [1:0] {
    ACT_RUN   = 2'd0,
    ACT_STALL = 2'd1,
    ACT_FLUSH = 2'd2
  } fe_act_e;

  // Control bundle produced for one action.
  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic ctrl_zero;
    logic flush;
  } fe_ctl_t;

  function automatic fe_ctl_t act_to_ctl(input fe_act_e act);
    fe_ctl_t c;
    c.pc_we     = 1'b1;
    c.ifid_we   = 1'b1;
    c.ctrl_zero = 1'b0;
    c.flush     = 1'b0;
    case (act)
      ACT_STALL: begin
        c.pc_we     = 1'b0;
        c.ifid_we   = 1'b0;
        c.ctrl_zero = 1'b1;
      end
      ACT_FLUSH: c.flush = 1'b1;
      default:   ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lu_detect.sv
module lu_detect #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_rd,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  output logic             hit_a,
  output logic             hit_b,
  output logic             hazard
);
  localparam logic [REG_W-1:0] ZERO_REG = {REG_W{1'b1}};

  // A load to the hard-wired zero register produces nothing to wait for.
  function automatic logic dep(input logic rd, input logic [REG_W-1:0] d,
                               input logic [REG_W-1:0] s);
    return rd && (d != ZERO_REG) && (d == s);
  endfunction

  logic dst_live;
  assign dst_live = mem_rd && (dst != ZERO_REG);
  assign hit_a    = dep(mem_rd, dst, src_a);
  assign hit_b    = dep(mem_rd, dst, src_b);
  assign hazard   = hit_a | hit_b;

  p_zero_reg_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dst == ZERO_REG) |-> !hazard);
  p_no_load_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |-> (!hit_a && !hit_b));
  p_hit_needs_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> dst_live);

endmodule

// File: rtl/fe_arbiter.sv
module fe_arbiter
  import hzd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hazard,
  input  logic    taken,
  output fe_act_e act
);
  // Stall outranks flush: the branch operands may depend on the load.
  always_comb begin
    if (hazard)     act = ACT_STALL;
    else if (taken) act = ACT_FLUSH;
    else            act = ACT_RUN;
  end

  p_stall_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> (act == ACT_STALL));
  p_flush_only_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_FLUSH) |-> taken);

endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_mem_rd_en,
  input  logic [REG_W-1:0] ex_dst,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             br_taken_id,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             idex_ctrl_zero,
  output logic             if_flush
);
  logic    hit_a;
  logic    hit_b;
  logic    hazard;
  fe_act_e act;
  fe_ctl_t ctl;

  lu_detect #(.REG_W(REG_W)) u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_rd (ex_mem_rd_en),
    .dst    (ex_dst),
    .src_a  (dec_src_a),
    .src_b  (dec_src_b),
    .hit_a  (hit_a),
    .hit_b  (hit_b),
    .hazard (hazard)
  );

  fe_arbiter u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .hazard (hazard),
    .taken  (br_taken_id),
    .act    (act)
  );

  assign ctl            = act_to_ctl(act);
  assign pc_we          = ctl.pc_we;
  assign ifid_we        = ctl.ifid_we;
  assign idex_ctrl_zero = ctl.ctrl_zero;
  assign if_flush       = ctl.flush;

  p_stall_freezes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idex_ctrl_zero |-> (!pc_we && !ifid_we));
  p_hit_stalls_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a || hit_b) |-> idex_ctrl_zero);
  p_flush_keeps_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |-> (pc_we && ifid_we && !idex_ctrl_zero));
  p_idle_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hazard && !br_taken_id) |-> (pc_we && ifid_we && !if_flush && !idex_ctrl_zero));
  p_one_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({idex_ctrl_zero, if_flush}));

endmodule

// File: tb/hzd_ctrl_tb.sv
module hzd_ctrl_tb;
  localparam int  REG_W = 5;
  localparam time CLK_P = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ld = 1'b0;
  logic [REG_W-1:0] rd = '0;
  logic [REG_W-1:0] sa = '0;
  logic [REG_W-1:0] sb = '0;
  logic             tk = 1'b0;
  logic             pc_we, ifid_we, czero, flush;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hzd_ctrl #(.REG_W(REG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ex_mem_rd_en(ld), .ex_dst(rd),
    .dec_src_a(sa), .dec_src_b(sb), .br_taken_id(tk),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_ctrl_zero(czero), .if_flush(flush)
  );

  // Expected {pc_we, ifid_we, ctrl_zero, flush}, written from the requirements.
  function automatic logic [3:0] model(input logic l, input logic [REG_W-1:0] d,
                                       input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                                       input logic t);
    logic stall;
    stall = 1'b0;
    if (l && d != 5'd31 && (d == a || d == b)) stall = 1'b1;
    if (stall) return 4'b0010;
    if (t)     return 4'b1101;
    return 4'b1100;
  endfunction

  // Apply on a falling edge, sample mid-phase.
  task automatic apply(input string req, input logic l, input logic [REG_W-1:0] d,
                       input logic [REG_W-1:0] a, input logic [REG_W-1:0] b, input logic t);
    logic [3:0] exp;
    logic [3:0] got;
    @(negedge clk);
    ld = l; rd = d; sa = a; sb = b; tk = t;
    #(CLK_P/4);
    exp = model(l, d, a, b, t);
    got = {pc_we, ifid_we, czero, flush};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (ld=%0b rd=%0d a=%0d b=%0d tk=%0b)",
               req, got, exp, l, d, a, b, t);
    end
  endtask

  task automatic t_reset;
    #(CLK_P/4);
    n_chk++;
    if ({pc_we, ifid_we, czero, flush} !== 4'b1100) begin
      n_bad++;
      $display("FAIL R7 reset: got %b expected 1100", {pc_we, ifid_we, czero, flush});
    end
  endtask

  task automatic t_match;
    apply("R1 src A", 1'b1, 5'd4, 5'd4, 5'd9, 1'b0);
    apply("R1 src B", 1'b1, 5'd7, 5'd2, 5'd7, 1'b0);
    apply("R2 no match", 1'b1, 5'd7, 5'd2, 5'd3, 1'b0);
    apply("R9 both", 1'b1, 5'd12, 5'd12, 5'd12, 1'b0);
    apply("R1 reg0", 1'b1, 5'd0, 5'd0, 5'd5, 1'b0);
  endtask

  task automatic t_zero_reg;
    apply("R3 both 31", 1'b1, 5'd31, 5'd31, 5'd31, 1'b0);
    apply("R3 a 31", 1'b1, 5'd31, 5'd31, 5'd1, 1'b0);
  endtask

  task automatic t_no_load;
    apply("R4 alu match", 1'b0, 5'd6, 5'd6, 5'd6, 1'b0);
    // Stall then bubble in EX: stall released after one cycle.
    apply("R4 stall cyc", 1'b1, 5'd9, 5'd1, 5'd9, 1'b0);
    apply("R4 bubble", 1'b0, 5'd0, 5'd1, 5'd9, 1'b0);
  endtask

  task automatic t_branch;
    apply("R5 taken", 1'b0, 5'd3, 5'd3, 5'd4, 1'b1);
    apply("R5 taken load nomatch", 1'b1, 5'd3, 5'd8, 5'd4, 1'b1);
    apply("R6 not taken", 1'b0, 5'd1, 5'd2, 5'd3, 1'b0);
    apply("R7 idle", 1'b0, 5'd0, 5'd0, 5'd0, 1'b0);
  endtask

  task automatic t_priority;
    apply("R8 stall+taken", 1'b1, 5'd10, 5'd10, 5'd2, 1'b1);
    apply("R8 retry", 1'b0, 5'd0, 5'd10, 5'd2, 1'b1);
    apply("R8 x31 taken", 1'b1, 5'd31, 5'd31, 5'd2, 1'b1);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 32; i++) begin
      apply("R1 sweep", 1'b1, 5'(i), 5'(i), 5'((i + 3) % 32), 1'b0);
      apply("R3 sweep", 1'b1, 5'(i), 5'((i + 1) % 32), 5'(i), 1'b1);
    end
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_match();
    t_zero_reg();
    t_no_load();
    t_branch();
    t_priority();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule